// File: doc/BRIEF.md
# Partial-Cell Timeout Padder

This block bounds how long a partly filled transmit buffer may be held back. Each channel's buffer is deliberately kept open while it is only partly full, so that later packets can share the same cell and raise line utilization. The block stops that wait from running on without limit. A table holds one remaining-time count per channel. A count starts when the first byte lands in an empty buffer. The count is cleared when the packer closes the buffer because it filled up.

A prescaler produces a periodic tick. Its period is programmable and a global enable switches it on. Each tick starts one sweep of the table. The sweep visits the channels in ascending order, one channel per clock cycle. Each enabled channel with a partly filled buffer loses one unit of its count. When a count runs out, the block raises a pad-and-close request naming that channel. The packer then zero-fills the remainder and hands the buffer on for transmission. Once the per-channel enables and timeouts are set, the block needs no further host action.

Top module: `fill_timeout_padder`

## Requirements
- R1: The tick fires when the prescaler count is at or above `tick_period`, so with `tick_en` high ticks are `tick_period`+1 cycles apart. While `tick_en` is low the prescaler is held at zero and no tick, and therefore no pad request, occurs.
- R2: A tick that arrives while a sweep is still running is discarded. This includes a tick in the cycle that visits the last channel.
- R3: A sweep begins in the cycle after its tick and visits channel 0, 1, … `N_CH`-1 on consecutive cycles. A pad request for the channel visited in cycle t appears in cycle t+1, so requests from one sweep come out in ascending channel order.
- R4: A `first_byte` pulse on an empty channel marks the buffer partly filled and loads that channel's `ch_init` value as its count. A `first_byte` pulse on a channel that is already partly filled has no effect, and its count is not reloaded.
- R5: At its visit, an enabled partly filled channel with a count above 1 is decremented by one. A count of 0 or 1 at the visit expires, so a timeout of N gives a pad on the Nth visited tick after loading, and 0 behaves like 1.
- R6: On expiry the block asserts `pad_valid` for one cycle with `pad_ch` holding the channel's binary index. The channel then returns to empty. `pad_ch` is zero whenever `pad_valid` is low.
- R7: A `fill_done` pulse empties the channel and clears its count. It takes priority over an expiry in the same cycle, so no pad is issued. It also takes priority over a `first_byte` pulse in the same cycle.
- R8: A channel whose `ch_en` bit is low is neither decremented nor padded, and its count is held. Once it is enabled, it resumes from the held value.
- R9: After reset all channels are empty, the prescaler and the sweep are idle, and `pad_valid` is low.
- R10: At most one pad request is issued per cycle, and at most one per channel per tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Global enable for tick generation |
| tick_period | input | PRESC_W | Tick spacing minus one, in cycles |
| ch_en | input | N_CH | Per-channel timer enable |
| ch_init | input | N_CH*CNT_W | Per-channel initial timeout, channel c in bits c*CNT_W upward |
| first_byte | input | N_CH | Pulse: first byte written into an empty buffer |
| fill_done | input | N_CH | Pulse: buffer closed because it is full |
| pad_valid | output | 1 | Pad-and-close request strobe |
| pad_ch | output | CH_W | Channel index of the request |

## Verification
The assertions assume that `first_byte` and `fill_done` are single-cycle strobes driven from the packer's own view of each buffer. They also assume that `ch_init` and `ch_en` for a channel hold steady around its load and visit cycles. The stimulus changes all inputs only on the inactive clock edge and pulses strobes for exactly one cycle. For the same-cycle priority cases it times a `fill_done` strobe onto the exact visit cycle that the reference model predicts. A short-period phase deliberately sends ticks into running sweeps, so that the discard path is exercised rather than avoided.

// File: rtl/fto_pkg.sv
// Shared types and helpers for the partial-cell timeout padder.
// Assumes nothing beyond IEEE 1800-2017 elaboration semantics.
package fto_pkg;

    // Sweep controller state: waiting for a tick, or walking the table.
    typedef enum logic {
        SWEEP_IDLE = 1'b0,
        SWEEP_RUN  = 1'b1
    } sweep_state_e;

    // Width of a channel index; at least one bit even for a single channel.
    function automatic int unsigned idx_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/fto_prescaler.sv
// Tick prescaler: emits a one-cycle tick every period_i+1 cycles while
// tick_en_i is high; holds its count at zero while disabled.
// Assumes period_i is quasi-static; a lowered period takes effect at once
// because the comparison is "at or above".
module fto_prescaler #(
    parameter int unsigned PRESC_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en_i,
    input  logic [PRESC_W-1:0] period_i,
    output logic               tick_o
);

    logic [PRESC_W-1:0] cnt_q;
    logic               tick_q;

    // Count cycles and raise the tick when the programmed spacing is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (!tick_en_i) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (cnt_q >= period_i) begin
            cnt_q  <= '0;
            tick_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_q <= 1'b0;
        end
    end

    assign tick_o = tick_q;

    AST_NO_TICK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en_i |=> !tick_o); // R1

    AST_COUNT_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en_i |=> cnt_q == '0); // R1

endmodule

// File: rtl/fto_sweep.sv
// Sweep controller: on a tick while idle, walks the channel table in
// ascending index order, one channel per cycle, and drives a one-hot visit
// strobe. Ticks arriving during a walk are discarded.
// Assumes tick_i is a single-cycle pulse.
module fto_sweep #(
    parameter int unsigned N_CH = 8,
    parameter int unsigned CH_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    output logic            busy_o,
    output logic [CH_W-1:0] idx_o,
    output logic [N_CH-1:0] visit_o
);

    import fto_pkg::*;

    localparam logic [CH_W-1:0] LAST = CH_W'(N_CH - 1);

    sweep_state_e    st_q;
    logic [CH_W-1:0] idx_q;

    // Advance the walk, or start one when a tick finds the controller idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SWEEP_IDLE;
            idx_q <= '0;
        end else begin
            case (st_q)
                SWEEP_IDLE: begin
                    if (tick_i) begin
                        st_q  <= SWEEP_RUN;
                        idx_q <= '0;
                    end
                end
                SWEEP_RUN: begin
                    if (idx_q == LAST) begin
                        st_q  <= SWEEP_IDLE;
                        idx_q <= '0;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: begin
                    st_q  <= SWEEP_IDLE;
                    idx_q <= '0;
                end
            endcase
        end
    end

    // One visit strobe per table entry.
    for (genvar g = 0; g < N_CH; g++) begin : g_visit
        assign visit_o[g] = (st_q == SWEEP_RUN) && (idx_q == CH_W'(g));
    end

    assign busy_o = (st_q == SWEEP_RUN);
    assign idx_o  = idx_q;

    AST_VISIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(visit_o)); // R10

    AST_SWEEP_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && idx_q != LAST) |=> (busy_o && idx_q == $past(idx_q) + 1'b1)); // R3

    AST_SWEEP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && idx_q == LAST) |=> !busy_o); // R2

    AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && tick_i) |=> (busy_o && idx_q == '0)); // R3

endmodule

// File: rtl/fto_chan_slot.sv
// One wait-table entry: tracks whether the channel's buffer is partly
// filled and its remaining count. Priority: fill completion, then the
// sweep visit (decrement or expire), then a first-byte load.
// Assumes first_i and fill_i are single-cycle strobes from the packer.
module fto_chan_slot #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CNT_W-1:0] init_i,
    input  logic             first_i,
    input  logic             fill_i,
    input  logic             visit_i,
    output logic             expire_o
);

    logic             active_q;
    logic [CNT_W-1:0] cnt_q;
    logic             due;
    logic             last_unit;

    assign due       = visit_i && active_q && en_i;
    assign last_unit = (cnt_q <= CNT_W'(1));
    assign expire_o  = due && last_unit && !fill_i;

    // Update the entry according to the fixed event priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (fill_i) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (due) begin
            if (last_unit) begin
                active_q <= 1'b0;
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (first_i && !active_q) begin
            active_q <= 1'b1;
            cnt_q    <= init_i;
        end
    end

    AST_CLEAR_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        fill_i |=> (!active_q && cnt_q == '0)); // R7

    AST_LOAD_ON_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (first_i && !active_q && !fill_i) |=> (active_q && cnt_q == $past(init_i))); // R4

    AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (first_i && active_q && !fill_i && !visit_i) |=> $stable(cnt_q)); // R4

    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && active_q && !fill_i) |=> (active_q && $stable(cnt_q))); // R8

endmodule

// File: rtl/fill_timeout_padder.sv
// Partial-cell timeout padder top: a prescaler tick starts a sweep over a
// table of per-channel countdowns; an expired partly filled buffer yields a
// registered pad-and-close request carrying the channel index.
// Assumes N_CH >= 1 and that the packer acts on every pad request.
module fill_timeout_padder #(
    parameter int unsigned N_CH    = 8,
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned PRESC_W = 12,
    localparam int unsigned CH_W   = fto_pkg::idx_width(N_CH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_en,
    input  logic [PRESC_W-1:0]    tick_period,
    input  logic [N_CH-1:0]       ch_en,
    input  logic [N_CH*CNT_W-1:0] ch_init,
    input  logic [N_CH-1:0]       first_byte,
    input  logic [N_CH-1:0]       fill_done,
    output logic                  pad_valid,
    output logic [CH_W-1:0]       pad_ch
);

    logic            tick;
    logic            sweep_busy;
    logic [CH_W-1:0] sweep_idx;
    logic [N_CH-1:0] visit;
    logic [N_CH-1:0] expire;
    logic [CH_W-1:0] expire_idx;
    logic            pad_valid_q;
    logic [CH_W-1:0] pad_ch_q;

    fto_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en_i(tick_en),
        .period_i (tick_period),
        .tick_o   (tick)
    );

    fto_sweep #(.N_CH(N_CH), .CH_W(CH_W)) u_sweep (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .busy_o (sweep_busy),
        .idx_o  (sweep_idx),
        .visit_o(visit)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_slot
        fto_chan_slot #(.CNT_W(CNT_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (ch_en[c]),
            .init_i  (ch_init[c*CNT_W +: CNT_W]),
            .first_i (first_byte[c]),
            .fill_i  (fill_done[c]),
            .visit_i (visit[c]),
            .expire_o(expire[c])
        );
    end

    // Encode the (at most one) expiring channel into a binary index.
    always_comb begin
        expire_idx = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (expire[i]) expire_idx = CH_W'(i);
        end
    end

    // Register the pad-and-close request; index is zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pad_valid_q <= 1'b0;
            pad_ch_q    <= '0;
        end else begin
            pad_valid_q <= |expire;
            pad_ch_q    <= (|expire) ? expire_idx : '0;
        end
    end

    assign pad_valid = pad_valid_q;
    assign pad_ch    = pad_ch_q;

    AST_PAD_FROM_VISIT: assert property (@(posedge clk) disable iff (!rst_n)
        pad_valid |-> $past(sweep_busy)); // R6

    AST_PAD_MATCHES_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
        pad_valid |-> pad_ch == $past(sweep_idx)); // R3

    AST_IDLE_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_valid |-> pad_ch == '0); // R6

    AST_SINGLE_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(expire)); // R10

endmodule

// File: tb/fill_timeout_padder_tb.sv
// Bench: behavioural cycle model of the padder compared on every clock,
// plus directed scenarios with tallies of pad requests per channel.
module fill_timeout_padder_tb;

    localparam int N     = 8;
    localparam int CW    = 8;
    localparam int PW    = 12;
    localparam int XW    = 3;
    localparam int CLK_P = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            tick_en = 1'b0;
    logic [PW-1:0]   tick_period = '0;
    logic [N-1:0]    ch_en = '0;
    logic [N*CW-1:0] ch_init = '0;
    logic [N-1:0]    first_byte = '0;
    logic [N-1:0]    fill_done = '0;
    logic            pad_valid;
    logic [XW-1:0]   pad_ch;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string phase = "R9";
    bit started = 0;
    int pads[N];

    // reference model state
    bit m_act[N];
    int m_cnt[N];
    int m_pc;
    bit m_tick, m_busy, m_padv;
    int m_idx, m_padc;

    fill_timeout_padder #(.N_CH(N), .CNT_W(CW), .PRESC_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tick_period(tick_period),
        .ch_en(ch_en), .ch_init(ch_init), .first_byte(first_byte),
        .fill_done(fill_done), .pad_valid(pad_valid), .pad_ch(pad_ch)
    );

    always #(CLK_P/2) clk = ~clk;

    // Behavioural model: next state from current state and inputs.
    always @(posedge clk) begin
        bit o_tick, o_busy;
        int o_idx;
        o_tick = m_tick; o_busy = m_busy; o_idx = m_idx;
        started = 1;
        if (!rst_n) begin
            for (int c = 0; c < N; c++) begin m_act[c] = 0; m_cnt[c] = 0; end
            m_pc = 0; m_tick = 0; m_busy = 0; m_idx = 0; m_padv = 0; m_padc = 0;
        end else begin
            m_padv = 0; m_padc = 0;
            for (int c = 0; c < N; c++) begin
                if (fill_done[c]) begin
                    m_act[c] = 0; m_cnt[c] = 0;
                end else if (o_busy && o_idx == c && m_act[c] && ch_en[c]) begin
                    if (m_cnt[c] <= 1) begin
                        m_act[c] = 0; m_cnt[c] = 0; m_padv = 1; m_padc = c;
                    end else m_cnt[c] = m_cnt[c] - 1;
                end else if (first_byte[c] && !m_act[c]) begin
                    m_act[c] = 1; m_cnt[c] = int'(ch_init[c*CW +: CW]);
                end
            end
            if (o_busy) begin
                if (o_idx == N-1) begin m_busy = 0; m_idx = 0; end
                else m_idx = o_idx + 1;
            end else if (o_tick) begin
                m_busy = 1; m_idx = 0;
            end
            if (!tick_en) begin m_pc = 0; m_tick = 0; end
            else if (m_pc >= int'(tick_period)) begin m_pc = 0; m_tick = 1; end
            else begin m_pc = m_pc + 1; m_tick = 0; end
        end
    end

    // Compare outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            checks++;
            if (pad_valid !== m_padv || int'(pad_ch) != m_padc) begin
                errors++;
                $display("FAIL %s: pad_valid/pad_ch actual %b/%0d expected %b/%0d at cycle %0d",
                         phase, pad_valid, pad_ch, m_padv, m_padc, cyc);
            end
            if (pad_valid === 1'b1) pads[pad_ch]++;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic tally(input string req, input int ch, input int exp);
        #1;
        checks++;
        if (pads[ch] != exp) begin
            errors++;
            $display("FAIL %s: pads on channel %0d actual %0d expected %0d", req, ch, pads[ch], exp);
        end
    endtask

    task automatic clear_pads();
        #1;
        for (int c = 0; c < N; c++) pads[c] = 0;
    endtask

    task automatic set_init(input int ch, input int v);
        ch_init[ch*CW +: CW] = CW'(v);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int ch, input bit first, input bit fill);
        @(negedge clk);
        first_byte[ch] = first;
        fill_done[ch]  = fill;
        @(negedge clk);
        first_byte = '0;
        fill_done  = '0;
    endtask

    initial begin
        for (int c = 0; c < N; c++) pads[c] = 0;
        ch_en = '1;
        tick_period = PW'(15);
        wait_cyc(4);
        rst_n = 1'b1;

        // R9: idle after reset, no requests
        phase = "R9";
        wait_cyc(10);
        for (int c = 0; c < N; c++) tally("R9", c, 0);

        // R1: ticks off, loaded channel never padded; then period 0
        phase = "R1";
        set_init(4, 1);
        pulse(4, 1, 0);
        wait_cyc(100);
        tally("R1", 4, 0);
        tick_period = '0;
        tick_en = 1'b1;
        wait_cyc(30);
        tally("R1", 4, 1);
        tick_period = PW'(15);
        clear_pads();

        // R5 / R6: timeout of 3 pads exactly once
        phase = "R5";
        set_init(2, 3);
        pulse(2, 1, 0);
        wait_cyc(100);
        tally("R5", 2, 1);
        clear_pads();

        // R4: second first_byte ignored, no reload
        phase = "R4";
        set_init(1, 2);
        pulse(1, 1, 0);
        wait_cyc(10);
        set_init(1, 9);
        pulse(1, 1, 0);
        wait_cyc(60);
        tally("R4", 1, 1);
        clear_pads();

        // R3: several channels expire in one sweep, ascending order
        phase = "R3";
        set_init(1, 1); set_init(4, 1); set_init(6, 1);
        @(negedge clk);
        first_byte = 8'b0101_0010;
        @(negedge clk);
        first_byte = '0;
        wait_cyc(40);
        tally("R3", 1, 1); tally("R3", 4, 1); tally("R3", 6, 1);
        clear_pads();

        // R7: fill_done on the visit cycle beats expiry; fill beats first_byte
        phase = "R7";
        set_init(3, 1);
        set_init(0, 1);
        pulse(3, 1, 0);
        pulse(0, 1, 1);
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (m_busy && m_idx == 3) begin
                fill_done[3] = 1'b1;
                @(negedge clk);
                fill_done = '0;
                break;
            end
        end
        wait_cyc(40);
        tally("R7", 3, 0);
        tally("R7", 0, 0);
        clear_pads();

        // R8: disabled channel holds its count, resumes when enabled
        phase = "R8";
        ch_en[5] = 1'b0;
        set_init(5, 1);
        pulse(5, 1, 0);
        wait_cyc(60);
        tally("R8", 5, 0);
        ch_en[5] = 1'b1;
        wait_cyc(40);
        tally("R8", 5, 1);
        clear_pads();

        // R2: ticks every 4 cycles collide with 8-cycle sweeps
        phase = "R2";
        tick_period = PW'(3);
        set_init(7, 2);
        pulse(7, 1, 0);
        wait_cyc(60);
        tally("R2", 7, 1);
        clear_pads();

        // R10: random traffic against the model
        phase = "R10";
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            first_byte = '0;
            fill_done  = '0;
            for (int c = 0; c < N; c++) begin
                if ($urandom_range(0, 19) == 0) first_byte[c] = 1'b1;
                if ($urandom_range(0, 39) == 0) fill_done[c] = 1'b1;
                if ($urandom_range(0, 99) == 0) ch_en[c] = ~ch_en[c];
                if ($urandom_range(0, 49) == 0) set_init(c, $urandom_range(0, 5));
            end
            if ($urandom_range(0, 199) == 0) tick_period = PW'($urandom_range(2, 20));
            if ($urandom_range(0, 299) == 0) tick_en = ~tick_en;
        end
        @(negedge clk);
        first_byte = '0;
        fill_done  = '0;
        wait_cyc(20);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule